// File: doc/BRIEF.md
# Four-Step Bidirectional Switch Commutator

This block sequences the six gate commands of one switch module that connects any one of three input phases to a single output line. Each of the three bidirectional switches is a pair of anti-series devices. Device 1 of a pair carries positive load current and device 2 carries negative load current. A controller selects the phase with a 2-bit code. When the code moves from one phase to another, the block does not swap switches in one step. It walks a four-step sequence chosen by the sign of the load current. The sequence never connects two input phases through opposite devices, and it never leaves the output without a conducting path.

The sign of the current is captured once, when a commutation begins, and stays fixed until the new switch is fully on, so a noisy sign near zero current cannot disturb the sequence. A short-circuit input blanks all gates at once without waiting for a clock. That fault is latched until a synchronous reset, and after the reset a fresh start command is needed. Each step lasts one clock period, so the clock is chosen to be slower than the turn-off delay of the devices.

Top module: `bidir_commutator`

## Requirements
- R1: Gate bus order is {A1,A2,B1,B2,C1,C2}, with bit 5 = A1 and bit 0 = C2. Select code 01 picks phase A, 10 picks phase B and 11 picks phase C. In a steady state both devices of the selected pair are on: A=110000, B=001100, C=000011.
- R2: After reset all gates are 0 and fault is 0. The gates stay 0 until start is seen at a clock edge together with a nonzero request. On that edge the block enters the steady state of the requested phase.
- R3: Positive sign (isign=1). On four consecutive clock edges the gates become: old device 1 only, then old device 1 plus new device 1, then new device 1 only, then new steady. For example, A to C gives 100000, 100010, 000010, 000011.
- R4: Negative sign (isign=0). The same four steps use device 2. For example, A to C gives 010000, 010001, 000001, 000011.
- R5: The sign is sampled at the edge that starts a commutation. Changes on isign during the following steps have no effect.
- R6: Select code 00 keeps the present state. A request equal to the present phase starts no commutation.
- R7: A nonzero code that arrives during a commutation is remembered, even if the select input returns to 00. It is acted on once the steady state is reached, and the latest such code wins.
- R8: Raising short_in drives all gates to 0 and fault to 1 at once, without a clock edge.
- R9: The fault stays latched and the gates stay 0 after short_in falls, and start is ignored. Reset clears the fault, and a new start is then needed before any gate turns on.
- R10: At no time are both devices of two switches on, or devices of opposite index on in two different switches.
- R11: Start while a switch is already conducting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Enables conduction from the off state |
| sel | input | 2 | Requested input phase (00 = hold) |
| isign | input | 1 | Load current sign, 1 = positive |
| short_in | input | 1 | Asynchronous short-circuit alarm |
| gate | output | 6 | Gate commands {A1,A2,B1,B2,C1,C2} |
| fault | output | 1 | Short-circuit flag to the controller |

## Verification
The bench walks all six ordered phase pairs in both current directions. It inverts isign right after each commutation starts: a design that samples the sign live would mix device 1 and device 2 and short two phases. It retargets the select code mid-sequence and then drops it to 00; a design that ignores the pending request stops on the wrong phase, and one that acts on it early breaks the sequence. It raises short_in between clock edges and then tries start before and after reset; a synchronous fault path would leave the gates on for part of a cycle, and a fault that is not latched would let conduction resume without reset.

// File: rtl/bcom_pkg.sv
package bcom_pkg;

  localparam int PHASES = 3;
  localparam int SELW   = $clog2(PHASES + 1);
  localparam int GW     = 2 * PHASES;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_HOLD,
    ST_STEP1,
    ST_STEP2,
    ST_STEP3
  } bcom_state_e;

  // device pair of one source placed on the gate bus; source 1 sits at the top
  function automatic logic [GW-1:0] dev_mask(input logic [SELW-1:0] src,
                                              input logic [1:0] devs);
    logic [GW-1:0] m;
    m = '0;
    if (src != '0) begin
      m[1:0] = devs;
      m = m << (2 * (PHASES - int'(src)));
    end
    return m;
  endfunction

  // device that carries the current: device 1 for positive, device 2 for negative
  function automatic logic [1:0] keep_dev(input logic pos);
    return pos ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [GW-1:0] gate_word(input bcom_state_e st,
                                               input logic [SELW-1:0] cur,
                                               input logic [SELW-1:0] tgt,
                                               input logic pos);
    logic [GW-1:0] g;
    case (st)
      ST_HOLD:  g = dev_mask(cur, 2'b11);
      ST_STEP1: g = dev_mask(cur, keep_dev(pos));
      ST_STEP2: g = dev_mask(cur, keep_dev(pos)) | dev_mask(tgt, keep_dev(pos));
      ST_STEP3: g = dev_mask(tgt, keep_dev(pos));
      default:  g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/bcom_req_hold.sv
module bcom_req_hold
  import bcom_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] sel,
  output logic [SELW-1:0] req
);

  logic [SELW-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst)              pend_q <= '0;
    else if (sel != '0)   pend_q <= sel;
  end

  assign req = (sel != '0) ? sel : pend_q;

endmodule

// File: rtl/bcom_fault_trap.sv
module bcom_fault_trap (
  input  logic clk,
  input  logic rst,
  input  logic short_in,
  output logic fault
);

  logic trap_q;

  always_ff @(posedge clk or posedge short_in) begin
    if (short_in)  trap_q <= 1'b1;
    else if (rst)  trap_q <= 1'b0;
  end

  assign fault = trap_q | short_in;

endmodule

// File: rtl/bcom_step_fsm.sv
module bcom_step_fsm
  import bcom_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            halt,
  input  logic            start,
  input  logic [SELW-1:0] req,
  input  logic            isign,
  output bcom_state_e     state,
  output logic [SELW-1:0] cur,
  output logic [SELW-1:0] tgt,
  output logic            dir_q,
  output logic            commit_start,
  output logic            land,
  output logic            engage
);

  always_comb begin
    engage       = (state == ST_OFF)   && start && (req != '0) && !halt;
    commit_start = (state == ST_HOLD)  && (req != '0) && (req != cur) && !halt;
    land         = (state == ST_STEP3) && !halt;
  end

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      state <= ST_OFF;
      cur   <= '0;
      tgt   <= '0;
      dir_q <= 1'b0;
    end else begin
      case (state)
        ST_OFF: if (engage) begin
          state <= ST_HOLD;
          cur   <= req;
        end
        ST_HOLD: if (commit_start) begin
          state <= ST_STEP1;
          tgt   <= req;
          dir_q <= isign;
        end
        ST_STEP1: state <= ST_STEP2;
        ST_STEP2: state <= ST_STEP3;
        ST_STEP3: begin
          state <= ST_HOLD;
          cur   <= tgt;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

endmodule

// File: rtl/bcom_gate_drive.sv
module bcom_gate_drive
  import bcom_pkg::*;
(
  input  bcom_state_e     state,
  input  logic [SELW-1:0] cur,
  input  logic [SELW-1:0] tgt,
  input  logic            dir_q,
  input  logic            fault,
  output logic [GW-1:0]   gate
);

  logic [GW-1:0] raw;

  always_comb begin
    raw  = gate_word(state, cur, tgt, dir_q);
    gate = fault ? '0 : raw;
  end

endmodule

// File: rtl/bidir_commutator.sv
module bidir_commutator
  import bcom_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      sel,
  input  logic            isign,
  input  logic            short_in,
  output logic [5:0]      gate,
  output logic            fault
);

  logic [SELW-1:0] req;
  bcom_state_e     state;
  logic [SELW-1:0] cur;
  logic [SELW-1:0] tgt;
  logic            dir_q;
  logic            commit_start;
  logic            land;
  logic            engage;
  logic            in_step;

  bcom_req_hold u_req (
    .clk (clk),
    .rst (rst),
    .sel (sel),
    .req (req)
  );

  bcom_fault_trap u_trap (
    .clk      (clk),
    .rst      (rst),
    .short_in (short_in),
    .fault    (fault)
  );

  bcom_step_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .halt         (fault),
    .start        (start),
    .req          (req),
    .isign        (isign),
    .state        (state),
    .cur          (cur),
    .tgt          (tgt),
    .dir_q        (dir_q),
    .commit_start (commit_start),
    .land         (land),
    .engage       (engage)
  );

  bcom_gate_drive u_drv (
    .state (state),
    .cur   (cur),
    .tgt   (tgt),
    .dir_q (dir_q),
    .fault (fault),
    .gate  (gate)
  );

  assign in_step = (state == ST_STEP1) || (state == ST_STEP2) || (state == ST_STEP3);

endmodule

// File: rtl/bcom_checker.sv
module bcom_checker (
  input logic       clk,
  input logic       rst,
  input logic [5:0] gate,
  input logic       fault,
  input logic       commit_start,
  input logic       land,
  input logic       in_step,
  input logic       dir_q
);

  logic [2:0] pair_on;
  logic [2:0] pair_full;
  assign pair_on   = {|gate[5:4], |gate[3:2], |gate[1:0]};
  assign pair_full = {&gate[5:4], &gate[3:2], &gate[1:0]};

  p_gates_blank_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> (gate == 6'b0));

  p_no_double_full_r10: assert property (@(posedge clk) disable iff (rst)
    ($countones(pair_full) <= 1) && ((pair_full != 3'b0) -> ($countones(pair_on) == 1)));

  p_same_polarity_r10: assert property (@(posedge clk) disable iff (rst)
    ($countones(pair_on) == 2) |-> (({gate[5], gate[3], gate[1]} == 3'b0) ||
                                     ({gate[4], gate[2], gate[0]} == 3'b0)));

  p_path_kept_r3: assert property (@(posedge clk) disable iff (rst || fault)
    (!$past(rst) && ($past(gate) != 6'b0)) |-> (gate != 6'b0));

  p_four_steps_r3: assert property (@(posedge clk) disable iff (rst || fault)
    commit_start |-> ##3 land);

  p_sign_frozen_r5: assert property (@(posedge clk) disable iff (rst || fault)
    (in_step && $past(in_step)) |-> $stable(dir_q));

  p_reset_off_r2: assert property (@(posedge clk)
    $past(rst) |-> (gate == 6'b0));

endmodule

bind bidir_commutator bcom_checker chk_i (
  .clk          (clk),
  .rst          (rst),
  .gate         (gate),
  .fault        (fault),
  .commit_start (commit_start),
  .land         (land),
  .in_step      (in_step),
  .dir_q        (dir_q)
);

// File: tb/bidir_commutator_tb_top.sv
module bidir_commutator_tb_top;

  logic       clk = 1'b0;
  logic       rst, start, isign, short_in;
  logic [1:0] sel;
  logic [5:0] gate;
  logic       fault;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  bidir_commutator dut_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sel      (sel),
    .isign    (isign),
    .short_in (short_in),
    .gate     (gate),
    .fault    (fault)
  );

  // {target code, sign, step1, step2, step3, steady}
  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {2'b10, 1'b1, 6'b100000, 6'b101000, 6'b001000, 6'b001100},
    {2'b11, 1'b1, 6'b001000, 6'b001010, 6'b000010, 6'b000011},
    {2'b01, 1'b1, 6'b000010, 6'b100010, 6'b100000, 6'b110000},
    {2'b11, 1'b1, 6'b100000, 6'b100010, 6'b000010, 6'b000011},
    {2'b10, 1'b1, 6'b000010, 6'b001010, 6'b001000, 6'b001100},
    {2'b01, 1'b1, 6'b001000, 6'b101000, 6'b100000, 6'b110000},
    {2'b10, 1'b0, 6'b010000, 6'b010100, 6'b000100, 6'b001100},
    {2'b11, 1'b0, 6'b000100, 6'b000101, 6'b000001, 6'b000011},
    {2'b01, 1'b0, 6'b000001, 6'b010001, 6'b010000, 6'b110000},
    {2'b11, 1'b0, 6'b010000, 6'b010001, 6'b000001, 6'b000011},
    {2'b10, 1'b0, 6'b000001, 6'b000101, 6'b000100, 6'b001100},
    {2'b01, 1'b0, 6'b000100, 6'b010100, 6'b010000, 6'b110000}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual gate/fault=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_safe(input string tag);
    int full;
    full = int'(&gate[5:4]) + int'(&gate[3:2]) + int'(&gate[1:0]);
    n_run++;
    if (full > 1 || ((|{gate[5], gate[3], gate[1]}) && (|{gate[4], gate[2], gate[0]})
                     && full == 0)) begin
      n_fail++;
      $display("FAIL %s: actual gate=%b expected a safe pattern", tag, gate);
    end
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; sel = 2'b00; isign = 1'b0; short_in = 1'b0;
    @(negedge clk);
    tick(); tick(); tick();
    chk("R2 reset state", {gate, fault}, 7'b0);
    rst = 1'b0;

    // start with no request stays off
    start = 1'b1;
    tick();
    chk("R2 start without request", {gate, fault}, 7'b0);
    sel = 2'b01;
    tick();
    chk("R1 start to A", {gate, fault}, {6'b110000, 1'b0});
    start = 1'b0; sel = 2'b00;
    tick();

    // main table walk
    for (int i = 0; i < NV; i++) begin
      sel   = VEC[i][26:25];
      isign = VEC[i][24];
      tick();
      chk(VEC[i][24] ? "R3 step1" : "R4 step1", {gate, fault}, {VEC[i][23:18], 1'b0});
      isign = ~VEC[i][24];
      sel   = 2'b00;
      tick();
      chk("R5 step2 sign frozen", {gate, fault}, {VEC[i][17:12], 1'b0});
      chk_safe("R10 step2");
      tick();
      chk("R5 step3 sign frozen", {gate, fault}, {VEC[i][11:6], 1'b0});
      tick();
      chk("R1 new steady", {gate, fault}, {VEC[i][5:0], 1'b0});
      tick();
      chk("R6 hold after landing", {gate, fault}, {VEC[i][5:0], 1'b0});
    end

    // R6: code 00 and same code do nothing (steady A now)
    sel = 2'b00;
    tick(); tick();
    chk("R6 code 00 holds", {gate, fault}, {6'b110000, 1'b0});
    sel = 2'b01;
    tick(); tick();
    chk("R6 same code holds", {gate, fault}, {6'b110000, 1'b0});

    // R11: start while conducting
    start = 1'b1;
    tick();
    chk("R11 start while steady", {gate, fault}, {6'b110000, 1'b0});
    start = 1'b0;

    // R7: retarget mid-sequence, latest nonzero wins
    isign = 1'b1; sel = 2'b10;
    tick();
    chk("R7 begin to B", {gate, fault}, {6'b100000, 1'b0});
    sel = 2'b01;
    tick();
    sel = 2'b11;
    tick();
    sel = 2'b00;
    chk("R7 still heading to B", {gate, fault}, {6'b001000, 1'b0});
    tick();
    chk("R7 lands on B", {gate, fault}, {6'b001100, 1'b0});
    tick();
    chk("R7 pending C begins", {gate, fault}, {6'b001000, 1'b0});
    tick(); tick(); tick();
    chk("R7 pending C reached", {gate, fault}, {6'b000011, 1'b0});

    // R8: asynchronous blanking between edges
    #1 short_in = 1'b1;
    #0.5;
    chk("R8 async blank", {gate, fault}, {6'b000000, 1'b1});
    @(negedge clk);
    short_in = 1'b0;
    tick();
    chk("R9 fault latched", {gate, fault}, {6'b000000, 1'b1});
    start = 1'b1; sel = 2'b10;
    tick(); tick();
    chk("R9 start ignored in fault", {gate, fault}, {6'b000000, 1'b1});
    start = 1'b0;
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R9 reset clears fault", {gate, fault}, 7'b0);
    tick();
    chk("R9 off until start", {gate, fault}, 7'b0);
    start = 1'b1;
    tick();
    chk("R9 restart to B", {gate, fault}, {6'b001100, 1'b0});
    start = 1'b0;

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule